// File: doc/BRIEF.md
# General-Purpose Event Register Bank and System Control Interrupt Combiner

This block holds the general-purpose event (GPE) status and enable bytes of a power-management controller. It merges them with externally held PM1 event status and enable bits into one level-sensitive system control interrupt (SCI). Software reaches the GPE bytes through a byte-wide register port. Wider bus accesses are split outside the block into byte accesses in ascending address order. A hotplug controller pulses a single event input when a slot gains or loses a device. That pulse latches a sticky status bit, and software clears the bit by writing a one to it.

The SCI is a combinational function of the registered GPE bytes and the PM1 inputs. It therefore follows every register write and every hotplug event with no added delay. The block also drives an arm request for the PM timer overflow interrupt. The timer counter and the PM1 control logic sit outside this block.

Top module: `gpe_sci_ctrl`

## Requirements
- R1: After reset every GPE byte reads 0x00, and `sci` is low while the PM1 inputs are zero.
- R2: Byte addresses map as follows: 0 is status byte 0, 1 is status byte 1, 2 is enable byte 0 and 3 is enable byte 1. `io_rdata` shows the addressed byte in the same cycle.
- R3: A write to an enable address stores `io_wdata` unchanged. The new value is readable from the next cycle.
- R4: A write to a status address clears each bit whose data bit is 1 and leaves each bit whose data bit is 0 as it was. A status write never sets a bit.
- R5: A one-cycle pulse on `hotplug_evt` sets bit 1 (value 0x02) of status byte 0 from the next cycle.
- R6: When `hotplug_evt` and a write clearing bit 1 of status byte 0 happen in the same cycle, the bit ends up set.
- R7: `sci` is high whenever `pm1_sts & pm1_en` has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock) set. Other PM1 bits have no effect on `sci`.
- R8: `sci` is high whenever bit 1 is set in both status byte 0 and enable byte 0. No other GPE bit and no bit of byte 1 affects `sci`.
- R9: `tmr_arm` is high exactly when `pm1_en[0]` is 1 and `pm1_sts[0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Byte write strobe |
| io_addr | input | 2 | Byte address inside the GPE window |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Addressed byte, combinational |
| pm1_sts | input | 16 | PM1 event status bits |
| pm1_en | input | 16 | PM1 event enable bits |
| hotplug_evt | input | 1 | One-cycle hotplug insert or remove event |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Request to arm the timer overflow interrupt |

## Verification
The hardest case to produce is a hotplug pulse in the same cycle as a software write that clears the very bit the pulse sets. Only this collision shows which of the two takes priority. The stimulus first latches the bit, then drives the clearing write and the pulse in one cycle. It reads the byte back on the next cycle. A long random phase then mixes writes, pulses and PM1 patterns so that such collisions recur under many enable settings.

// File: rtl/gpe_sci_pkg.sv
package gpe_sci_pkg;
    localparam int PM1_W      = 16;
    localparam int TMR_BIT    = 0;
    localparam int GLK_BIT    = 5;
    localparam int PWRBTN_BIT = 8;
    localparam int RTC_BIT    = 10;
    localparam int HP_BIT     = 1;

    localparam logic [PM1_W-1:0] PM1_SCI_MASK =
        (PM1_W'(1) << TMR_BIT) | (PM1_W'(1) << GLK_BIT) |
        (PM1_W'(1) << PWRBTN_BIT) | (PM1_W'(1) << RTC_BIT);
endpackage

// File: rtl/gpe_regbank.sv
module gpe_regbank
    import gpe_sci_pkg::*;
#(
    parameter int NBYTES = 4,
    localparam int HALF = NBYTES / 2,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          hp_evt,
    output logic [7:0]    rdata,
    output logic [7:0]    sts0,
    output logic [7:0]    en0
);
    typedef struct packed {
        logic [HALF-1:0][7:0] sts;
        logic [HALF-1:0][7:0] en;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        int ai;
        ai = int'(addr);
        bank_d = bank_q;
        if (wr) begin
            if (ai < HALF)
                bank_d.sts[ai] = bank_q.sts[ai] & ~wdata;
            else
                bank_d.en[ai-HALF] = wdata;
        end
        // event after clear: set wins
        if (hp_evt)
            bank_d.sts[0][HP_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        int ri;
        ri = int'(addr);
        if (ri < HALF) rdata = bank_q.sts[ri];
        else           rdata = bank_q.en[ri-HALF];
    end

    assign sts0 = bank_q.sts[0];
    assign en0  = bank_q.en[0];

    // R5
    hp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_evt |=> sts0[HP_BIT]);

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == '0 && wdata[HP_BIT] && !hp_evt) |=> !sts0[HP_BIT]);

    // R4
    no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hp_evt && !sts0[0]) |=> !sts0[0]);

    // R3
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && int'(addr) == HALF) |=> $stable(en0));
endmodule

// File: rtl/gpe_sci_merge.sv
module gpe_sci_merge
    import gpe_sci_pkg::*;
(
    input  logic [PM1_W-1:0] pm1_sts,
    input  logic [PM1_W-1:0] pm1_en,
    input  logic [7:0]       gsts0,
    input  logic [7:0]       gen0,
    output logic             sci,
    output logic             tmr_arm
);
    logic pm1_hit, gpe_hit;

    always_comb begin
        pm1_hit = |(pm1_sts & pm1_en & PM1_SCI_MASK);
        gpe_hit = gsts0[HP_BIT] & gen0[HP_BIT];
        sci     = pm1_hit | gpe_hit;
        tmr_arm = pm1_en[TMR_BIT] & ~pm1_sts[TMR_BIT];
    end
endmodule

// File: rtl/gpe_sci_ctrl.sv
module gpe_sci_ctrl
    import gpe_sci_pkg::*;
#(
    parameter int GPE_LEN = 4,
    localparam int AW = $clog2(GPE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [AW-1:0]    io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [PM1_W-1:0] pm1_sts,
    input  logic [PM1_W-1:0] pm1_en,
    input  logic             hotplug_evt,
    output logic             sci,
    output logic             tmr_arm
);
    logic [7:0] sts0, en0;

    gpe_regbank #(.NBYTES(GPE_LEN)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr),
        .wdata(io_wdata), .hp_evt(hotplug_evt), .rdata(io_rdata),
        .sts0(sts0), .en0(en0)
    );

    gpe_sci_merge u_merge (
        .pm1_sts(pm1_sts), .pm1_en(pm1_en), .gsts0(sts0), .gen0(en0),
        .sci(sci), .tmr_arm(tmr_arm)
    );

    // R8
    gpe_sci_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts0[HP_BIT] && en0[HP_BIT]) |-> sci);

    // R7
    pm1_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pm1_sts & pm1_en & PM1_SCI_MASK) == '0 && !(sts0[HP_BIT] && en0[HP_BIT]))
        |-> !sci);

    // R9
    tmr_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pm1_sts[TMR_BIT] |-> !tmr_arm);
endmodule

// File: tb/sim_gpe_sci_ctrl.sv
module sim_gpe_sci_ctrl;
    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        io_wr = 0;
    logic [1:0]  io_addr = 0;
    logic [7:0]  io_wdata = 0;
    logic [7:0]  io_rdata;
    logic [15:0] pm1_sts = 0;
    logic [15:0] pm1_en = 0;
    logic        hotplug_evt = 0;
    logic        sci, tmr_arm;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R1";

    int m_byte [4];

    always #(PERIOD/2) clk = ~clk;

    gpe_sci_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .pm1_sts(pm1_sts),
        .pm1_en(pm1_en), .hotplug_evt(hotplug_evt), .sci(sci), .tmr_arm(tmr_arm)
    );

    // behavioural reference: 0,1 status; 2,3 enable
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_byte[i]) m_byte[i] = 0;
        end else begin
            if (io_wr) begin
                if (io_addr < 2) m_byte[io_addr] = m_byte[io_addr] & ~int'(io_wdata);
                else             m_byte[io_addr] = int'(io_wdata);
            end
            if (hotplug_evt) m_byte[0] = m_byte[0] | 2;
        end
    end

    task automatic chk(string r, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int pm, exp_sci, exp_arm;
            pm = int'(pm1_sts & pm1_en);
            exp_sci = ((pm & 'h0521) != 0) || ((m_byte[0] & m_byte[2] & 2) != 0);
            exp_arm = pm1_en[0] && !pm1_sts[0];
            chk(tag, int'(io_rdata), m_byte[io_addr], "rdata");
            chk(tag, int'(sci), exp_sci, "sci");
            chk(tag, int'(tmr_arm), exp_arm, "tmr_arm");
        end
    end

    task automatic cyc(bit w, int a, int d, bit hp);
        @(negedge clk);
        #1;
        io_wr = w; io_addr = 2'(a); io_wdata = 8'(d); hotplug_evt = hp;
    endtask

    task automatic rd(int a);
        cyc(0, a, 0, 0);
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 R2: every byte zero after reset
        tag = "R1";
        for (int a = 0; a < 4; a++) rd(a);
        // R3: enable bytes store data
        tag = "R3";
        cyc(1, 2, 'hA5, 0); cyc(1, 3, 'h3C, 0);
        rd(2); rd(3); rd(0);
        // R5: hotplug sets bit1; enable0 bit1 clear so no sci (R8)
        tag = "R5";
        cyc(0, 0, 0, 1); rd(0); rd(1);
        tag = "R8";
        cyc(1, 2, 'h02, 0); rd(0);
        // R4: zero bits keep, one bits clear
        tag = "R4";
        cyc(1, 0, 'hFD, 0); rd(0);
        cyc(1, 0, 'h02, 0); rd(0);
        cyc(1, 1, 'hFF, 0); rd(1);
        // R6: set and clear collide
        tag = "R6";
        cyc(0, 0, 0, 1); rd(0);
        cyc(1, 0, 'h02, 1); rd(0); rd(0);
        // R8: other enable bits do not raise sci
        tag = "R8";
        cyc(1, 2, 'hFD, 0); rd(0); cyc(1, 3, 'hFF, 0); rd(0);
        cyc(1, 2, 'h00, 0);
        // R7: each PM1 bit alone
        tag = "R7";
        for (int b = 0; b < 16; b++) begin
            pm1_sts = 16'(1 << b); pm1_en = 16'hFFFF; rd(0);
            pm1_sts = 16'hFFFF; pm1_en = 16'(1 << b); rd(0);
            pm1_sts = 16'(1 << b); pm1_en = ~16'(1 << b); rd(0);
        end
        // R9: timer arm
        tag = "R9";
        pm1_en = 16'h0001; pm1_sts = 16'h0000; rd(0);
        pm1_sts = 16'h0001; rd(0);
        pm1_en = 16'h0000; pm1_sts = 16'h0000; rd(0);
        // mixed traffic
        tag = "R4";
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = int'($urandom);
            pm1_sts = 16'($urandom); pm1_en = 16'($urandom & 32'h0000_0521 & $urandom);
            cyc(r[0], r[3:2], r[15:8], r[4] & r[5]);
        end
        cyc(0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule